// File: doc/BRIEF.md
# IEC-60958 subframe formatter

This block is a streaming datapath that turns interleaved audio words into the 32-bit subframe words an audio transmitter consumes. It has two input formats, chosen by a mode input.

In packed-subframe mode each input word already holds the control bits, the audio and a preamble code. The block moves the fields into place and turns the preamble's block-start code into a flag. In 24-bit PCM mode each input word carries a bare sample. The block adds a per-channel channel-status bit, a block-start flag on the first subframe of each 192-frame block, and an even-parity bit.

The status bits come from a 32-bit consumer seed, with the channel-number field rewritten for each channel. Words enter and leave through valid/ready handshakes. The channel count, the seed and a restart strobe come from configuration inputs.

Top module: `iec_subframe_fmt`

## Requirements
- R1: After reset out_valid is 0 and in_ready is 1, and the first PCM word accepted is treated as frame 0, channel 0.
- R2: With cfg_mode = 0 (packed), the output is {3'b000, in[3], in[31:4]}: the four control bits land in bits 27:24, the audio in 23:0, and preamble bit 3 (code 8 = block start) becomes bit 28. Bits 31:29 are 0.
- R3: With cfg_mode = 1 (24-bit PCM), output bits 23:0 equal input bits 23:0, bits 25:24 and 31:29 are 0, and input bits 31:24 are discarded.
- R4: In PCM mode output bit 28 is 1 exactly for frame 0, channel 0.
- R5: In PCM mode output bit 26 carries the channel-status bit. For frame f below 32 it is seed bit f (seed byte k in bits 8k+7:8k, each byte sent LSB first). For frames 32 to 191 it is 0.
- R6: For frames 20 to 23 (bits 7:4 of status byte 2), bit 26 carries bit f-20 of the value c+1, where c is the channel index 0 to 7, instead of the seed.
- R7: In PCM mode output bit 27 is set so that output bits 27:0 hold an even number of ones.
- R8: The channel index steps on every accepted word and wraps after N words, where N is cfg_chans clamped to the range 2 to 8. On each wrap the frame index steps, going from 191 back to 0.
- R9: A restart pulse, or a change of cfg_mode, holds in_ready low for that cycle and returns both indices to 0.
- R10: An accepted word appears on the output on the next cycle. While out_valid is high and out_ready is low, the output word holds, nothing is accepted and the indices do not move. in_ready is (!out_valid || out_ready) outside R9 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | 0 = packed subframes, 1 = 24-bit PCM |
| cfg_chans | input | 4 | Channels per frame (clamped to 2..8) |
| cfg_seed | input | 32 | Consumer channel-status seed, byte 0 in bits 7:0 |
| restart | input | 1 | Restart pulse that clears frame and channel indices |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted on this edge when valid |
| in_data | input | 32 | Input audio word |
| out_valid | output | 1 | Output subframe valid |
| out_ready | input | 1 | Downstream accepts the output subframe |
| out_data | output | 32 | Formatted subframe |

## Verification
The assertions assume that the configuration inputs change only while no word is being accepted. cfg_chans and cfg_seed are changed only together with a restart or while in_valid is low, so every word is formatted against a settled count and seed. The bench drives inputs on the falling edge only, applies random samples and random output stalls from a fixed seed, and steers directed cases onto the frame wrap, the channel-number frames, count clamping and mid-stream restarts.

// File: rtl/iec_fmt_pkg.sv
package iec_fmt_pkg;

  typedef enum logic {
    FMT_PACKED = 1'b0,
    FMT_PCM24  = 1'b1
  } fmt_mode_e;

  localparam int WORD_W  = 32;
  localparam int AUDIO_W = 24;
  localparam int PRE_W   = 4;
  localparam int CS_POS  = 26;
  localparam int PAR_POS = 27;
  localparam int BS_POS  = 28;

endpackage

// File: rtl/iec_frame_ctr.sv
module iec_frame_ctr #(
  parameter int FRAMES  = 192,
  parameter int MAX_CH  = 8,
  parameter int FRAME_W = $clog2(FRAMES),
  parameter int CH_W    = $clog2(MAX_CH),
  parameter int CNT_W   = $clog2(MAX_CH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               step,
  input  logic [CNT_W-1:0]   n_ch,
  output logic [FRAME_W-1:0] frame,
  output logic [CH_W-1:0]    ch
);

  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(FRAMES - 1);

  logic ch_last;
  assign ch_last = (CNT_W'(ch) + CNT_W'(1)) >= n_ch;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      frame <= '0;
      ch    <= '0;
    end else if (step) begin
      if (ch_last) begin
        ch    <= '0;
        frame <= (frame == LAST_FRAME) ? '0 : frame + FRAME_W'(1);
      end else begin
        ch <= ch + CH_W'(1);
      end
    end
  end

  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (rst)
    frame <= LAST_FRAME); // R8

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !clear && ch_last && frame == LAST_FRAME) |=> (frame == '0 && ch == '0)); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (frame == '0 && ch == '0)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !clear) |=> ($stable(frame) && $stable(ch))); // R10

endmodule

// File: rtl/iec_cs_gen.sv
module iec_cs_gen #(
  parameter int FRAME_W   = 8,
  parameter int CH_W      = 3,
  parameter int SEED_BITS = 32,
  parameter int CHNUM_LSB = 20,
  parameter int CHNUM_W   = 4
) (
  input  logic [FRAME_W-1:0]   frame,
  input  logic [CH_W-1:0]      ch,
  input  logic [SEED_BITS-1:0] seed,
  output logic                 cs_bit
);

  localparam int FIDX_W = $clog2(SEED_BITS);
  localparam logic [FRAME_W-1:0] SEED_LIM = FRAME_W'(SEED_BITS);

  logic [SEED_BITS-1:0] chan_status;
  logic [CHNUM_W-1:0]   chan_num;

  always_comb begin
    chan_num = CHNUM_W'(ch) + CHNUM_W'(1);
    chan_status = seed;
    chan_status[CHNUM_LSB +: CHNUM_W] = chan_num;
    if (frame < SEED_LIM) cs_bit = chan_status[frame[FIDX_W-1:0]];
    else                  cs_bit = 1'b0;
  end

endmodule

// File: rtl/iec_word_fmt.sv
module iec_word_fmt
  import iec_fmt_pkg::*;
(
  input  fmt_mode_e          mode,
  input  logic [WORD_W-1:0]  in_w,
  input  logic               cs_bit,
  input  logic               blk_start,
  output logic [WORD_W-1:0]  out_w
);

  always_comb begin
    out_w = '0;
    if (mode == FMT_PCM24) begin
      out_w[AUDIO_W-1:0] = in_w[AUDIO_W-1:0];
      out_w[CS_POS]      = cs_bit;
      out_w[PAR_POS]     = ^{cs_bit, in_w[AUDIO_W-1:0]};
      out_w[BS_POS]      = blk_start;
    end else begin
      out_w[WORD_W-PRE_W-1:0] = in_w[WORD_W-1:PRE_W];
      out_w[BS_POS]           = in_w[PRE_W-1];
    end
  end

endmodule

// File: rtl/iec_subframe_fmt.sv
module iec_subframe_fmt
  import iec_fmt_pkg::*;
#(
  parameter int MAX_CH    = 8,
  parameter int MIN_CH    = 2,
  parameter int FRAMES    = 192,
  parameter int SEED_BITS = 32,
  parameter int CHNUM_LSB = 20,
  parameter int CHNUM_W   = 4,
  localparam int CNT_W    = $clog2(MAX_CH + 1),
  localparam int CH_W     = $clog2(MAX_CH),
  localparam int FRAME_W  = $clog2(FRAMES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_mode,
  input  logic [CNT_W-1:0]     cfg_chans,
  input  logic [SEED_BITS-1:0] cfg_seed,
  input  logic                 restart,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [WORD_W-1:0]    in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [WORD_W-1:0]    out_data
);

  localparam logic [CNT_W-1:0] LO_CH = CNT_W'(MIN_CH);
  localparam logic [CNT_W-1:0] HI_CH = CNT_W'(MAX_CH);

  fmt_mode_e          mode_q;
  logic               out_pcm_q;
  logic               clr;
  logic               accept;
  logic [CNT_W-1:0]   n_eff;
  logic [FRAME_W-1:0] frame;
  logic [CH_W-1:0]    ch;
  logic               cs_bit;
  logic               blk_start;
  logic [WORD_W-1:0]  fmt_w;

  assign clr      = restart || (cfg_mode != mode_q);
  assign in_ready = (!out_valid || out_ready) && !clr;
  assign accept   = in_valid && in_ready;

  always_comb begin
    if (cfg_chans < LO_CH)      n_eff = LO_CH;
    else if (cfg_chans > HI_CH) n_eff = HI_CH;
    else                        n_eff = cfg_chans;
  end

  iec_frame_ctr #(
    .FRAMES (FRAMES),
    .MAX_CH (MAX_CH),
    .FRAME_W(FRAME_W),
    .CH_W   (CH_W),
    .CNT_W  (CNT_W)
  ) ctr_i (
    .clk  (clk),
    .rst  (rst),
    .clear(clr),
    .step (accept),
    .n_ch (n_eff),
    .frame(frame),
    .ch   (ch)
  );

  iec_cs_gen #(
    .FRAME_W  (FRAME_W),
    .CH_W     (CH_W),
    .SEED_BITS(SEED_BITS),
    .CHNUM_LSB(CHNUM_LSB),
    .CHNUM_W  (CHNUM_W)
  ) cs_i (
    .frame (frame),
    .ch    (ch),
    .seed  (cfg_seed),
    .cs_bit(cs_bit)
  );

  assign blk_start = (frame == '0) && (ch == '0);

  iec_word_fmt fmt_i (
    .mode     (mode_q),
    .in_w     (in_data),
    .cs_bit   (cs_bit),
    .blk_start(blk_start),
    .out_w    (fmt_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= FMT_PACKED;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_pcm_q <= 1'b0;
    end else begin
      mode_q <= fmt_mode_e'(cfg_mode);
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= fmt_w;
        out_pcm_q <= (mode_q == FMT_PCM24);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10

  AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_pcm_q) |-> (^out_data[PAR_POS:0] == 1'b0)); // R7

  AST_PACKED_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_pcm_q) |-> (out_data[WORD_W-1:BS_POS+1] == '0)); // R2

  AST_RESTART_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    restart |-> !in_ready); // R9

  AST_BS_FIRST_ONLY: assert property (@(posedge clk) disable iff (rst)
    (accept && mode_q == FMT_PCM24 && (frame != '0 || ch != '0)) |=> !out_data[BS_POS]); // R4

endmodule

// File: tb/iec_subframe_fmt_tb.sv
module iec_subframe_fmt_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_mode = 1'b0;
  logic [3:0]  cfg_chans = 4'd2;
  logic [31:0] cfg_seed = 32'h0;
  logic        restart = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = 32'h0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  always #10 clk = ~clk;

  iec_subframe_fmt dut_i (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_chans(cfg_chans),
    .cfg_seed(cfg_seed), .restart(restart), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int m_frame = 0;
  int m_ch    = 0;
  bit wrapped = 1'b0;
  bit first_after_rst = 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int clampn(input int c);
    if (c < 2) return 2;
    if (c > 8) return 8;
    return c;
  endfunction

  function automatic logic cs_exp(input int f, input int c, input logic [31:0] seed);
    logic [31:0] st;
    st = seed;
    if (f >= 32) return 1'b0;
    st[23:20] = 4'(c + 1);
    return st[f];
  endfunction

  function automatic logic [31:0] exp_word(input logic pcm, input logic [31:0] w,
                                           input int f, input int c, input logic [31:0] seed);
    logic [31:0] e;
    logic cs;
    e = 32'h0;
    if (pcm) begin
      cs = cs_exp(f, c, seed);
      e[23:0] = w[23:0];
      e[26] = cs;
      e[27] = ^{cs, w[23:0]};
      e[28] = (f == 0 && c == 0);
    end else begin
      e = {3'b000, w[3], w[31:4]};
    end
    return e;
  endfunction

  task automatic push(input logic [31:0] w, input int hold);
    logic [31:0] e;
    @(negedge clk);
    in_valid = 1'b1; in_data = w; out_ready = (hold == 0);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    e = exp_word(cfg_mode, w, m_frame, m_ch, cfg_seed);
    chk(out_valid === 1'b1, "R10 latency", {31'h0, out_valid}, 32'h1);
    if (cfg_mode) begin
      chk(out_data[23:0] === e[23:0] && out_data[31:29] === 3'b000 && out_data[25:24] === 2'b00,
          "R3 sample field", out_data, e);
      if (first_after_rst)
        chk(out_data[28] === 1'b1, "R1 first word is frame 0", out_data, e);
      else if (wrapped)
        chk(out_data[28] === 1'b1, "R8 wrap to frame 0", out_data, e);
      else
        chk(out_data[28] === e[28], "R4 block start", out_data, e);
      if (m_frame >= 20 && m_frame <= 23)
        chk(out_data[26] === e[26], "R6 channel number", out_data, e);
      else
        chk(out_data[26] === e[26], "R5 status bit", out_data, e);
      chk(^out_data[27:0] === 1'b0 && out_data[27] === e[27], "R7 parity", out_data, e);
    end else begin
      chk(out_data === e, "R2 packed", out_data, e);
    end
    first_after_rst = 1'b0;
    wrapped = 1'b0;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(out_valid === 1'b1 && out_data === e && in_ready === 1'b0, "R10 stall hold", out_data, e);
    end
    if (hold > 0) out_ready = 1'b1;
    m_ch++;
    if (m_ch >= clampn(int'(cfg_chans))) begin
      m_ch = 0;
      if (m_frame == 191) begin m_frame = 0; wrapped = 1'b1; end
      else m_frame++;
    end
  endtask

  function automatic int rand_hold();
    if ($urandom % 8 == 0) return int'($urandom % 3) + 1;
    return 0;
  endfunction

  task automatic do_restart();
    @(negedge clk);
    restart = 1'b1;
    #1;
    chk(in_ready === 1'b0, "R9 restart blocks input", {31'h0, in_ready}, 32'h0);
    @(negedge clk);
    restart = 1'b0;
    m_frame = 0; m_ch = 0; wrapped = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    cfg_mode = m;
    #1;
    chk(in_ready === 1'b0, "R9 mode change blocks input", {31'h0, in_ready}, 32'h0);
    m_frame = 0; m_ch = 0; wrapped = 1'b0;
  endtask

  task automatic run_words(input int n);
    for (int i = 0; i < n; i++) push($urandom, rand_hold());
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    cfg_seed = 32'hC3A5_5A3C;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 reset out_valid", {31'h0, out_valid}, 32'h0);
    chk(in_ready === 1'b1, "R1 reset in_ready", {31'h0, in_ready}, 32'h1);

    // packed mode: directed preamble codes then random words
    push(32'hF123_4568, 0);
    push(32'h0ABC_DEF4, 0);
    push(32'h5555_5552, 1);
    run_words(20);

    // PCM, two channels, past the 191 -> 0 wrap
    set_mode(1'b1);
    first_after_rst = 1'b1;
    run_words(2 * 200);

    // eight channels: channel numbers 1..8 in frames 20..23
    @(negedge clk); cfg_chans = 4'd8; cfg_seed = $urandom;
    do_restart();
    first_after_rst = 1'b1;
    run_words(8 * 40);

    // three channels, new seed
    @(negedge clk); cfg_chans = 4'd3; cfg_seed = 32'hFFFF_FFFF;
    do_restart();
    run_words(3 * 35);

    // clamping below and above the legal range
    @(negedge clk); cfg_chans = 4'd1;
    do_restart();
    run_words(2 * 3);
    @(negedge clk); cfg_chans = 4'd15;
    do_restart();
    run_words(8 * 3);

    // mid-stream restart
    @(negedge clk); cfg_chans = 4'd6;
    do_restart();
    run_words(5);
    do_restart();
    first_after_rst = 1'b1;
    run_words(4);

    // back to packed, then PCM again
    set_mode(1'b0);
    push(32'h1234_5678, 0);
    run_words(10);
    set_mode(1'b1);
    first_after_rst = 1'b1;
    run_words(4);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule